// File: doc/BRIEF.md
# Single-Channel Block-Transfer DMA Controller

This block moves a block of words between main memory and one peripheral without the processor touching each word. Software programs a start address, a word count and a control word through a small register port, then sets a start bit. The controller asks for the system bus, waits for a grant, and carries out one memory access per word. After each word it steps the address by four bytes and lowers the remaining count. When the last word reaches its destination it sets a done flag and, if enabled, raises an interrupt.

Two bus policies are offered. In cycle-stealing mode the controller gives the bus back after every memory access and asks again for the next word. In block mode it keeps the bus from the first grant until the final memory access. Peripheral data flows through valid/ready streams. A transmitter holds valid and keeps its data unchanged until ready is seen high at a clock edge. A receiver may hold ready low for as long as it needs. The memory port follows the same rule, with `mem_ready` completing an access in the cycle it is high. Read data is taken in that same cycle.

Top module: `dma_block_ctrl`

## Requirements
- R1: After reset, all three registers read as zero, and `bus_req`, `mem_valid`, `per_in_ready`, `per_out_valid` and `irq` are low.
- R2: `reg_addr` selects a word: 0 is the address, 1 is the remaining count, 2 is the control word. The control word reads as {bit31 irq flag, bit30 irq enable, bits 29:3 zero, bit2 mode, bit1 direction, bit0 done}. Writes to the address, the count, the mode or the direction are ignored while a transfer runs. Reads are combinational.
- R3: Each completed memory access adds 4 to the address register and subtracts 1 from the count register, one clock edge after the access. Both registers can be read back at any time.
- R4: Done (bit 0) is set at the clock edge where the last word reaches its destination. If the irq enable bit (bit 30) is 1, the irq flag (bit 31) and the `irq` port go high at that same edge.
- R5: `mem_valid` is only high while `bus_req` is high and the grant has been received. `bus_req` stays high until `bus_grant` arrives.
- R6: With mode bit 2 = 0 (cycle stealing), `bus_req` drops in the cycle after each completed memory access. There is one request episode per word.
- R7: With mode bit 2 = 1 (block), `bus_req` stays high from the first grant until the final memory access. There is one request episode per block.
- R8: Writing the control word with bit 31 = 1 clears the irq flag and drops `irq`, unless a completion sets it at the same edge.
- R9: Writing the control word with bit 3 = 1 while idle clears done and irq and starts a transfer. Bit 3 always reads 0. A start with a count of 0 sets done at once, never requests the bus, and sets irq if bit 30 of that write is 1.
- R10: Direction bit 1 = 1 takes words from the peripheral input stream and writes them to memory. Bit 1 = 0 reads memory and sends the words on the peripheral output stream. In both directions words go in ascending address order.
- R11: `mem_valid` and `per_out_valid` stay high with their address and data unchanged until the matching ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt output, mirrors the irq flag |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_valid | output | 1 | Memory access pending |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| per_in_valid | input | 1 | Peripheral word offered |
| per_in_ready | output | 1 | Controller accepts a peripheral word |
| per_in_data | input | DATA_W | Peripheral input word |
| per_out_valid | output | 1 | Word offered to the peripheral |
| per_out_ready | input | 1 | Peripheral accepts the word |
| per_out_data | output | DATA_W | Peripheral output word |

## Verification
The bench goes after the bus policy boundaries. It counts request episodes per block. A controller that keeps the bus in cycle-stealing mode, or drops it between words in block mode, gives the wrong episode count. It starts a transfer with a zero count; a design that requested the bus anyway, or never flagged done, would hang or show a spurious request. It writes the address and count in the middle of a transfer, stalls the grant, the memory and both streams, and checks the completion timing. Each clock it compares against its model, which exposes a design that skips or repeats a word under back-pressure, sets done one word early in the memory-to-peripheral direction, or fails to clear the irq flag on a write-one-to-clear.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_REQ,
    PH_MEM,
    PH_PUSH
  } phase_t;

  localparam int unsigned OFS_ADDR  = 0;
  localparam int unsigned OFS_COUNT = 1;
  localparam int unsigned OFS_CTRL  = 2;

  localparam int unsigned B_IRQ  = 31;
  localparam int unsigned B_IE   = 30;
  localparam int unsigned B_GO   = 3;
  localparam int unsigned B_MODE = 2;
  localparam int unsigned B_DIR  = 1;
  localparam int unsigned B_DONE = 0;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/dma_csr.sv
module dma_csr
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              step,
  input  logic              finish,
  output logic              go,
  output logic              go_dir,
  output logic              cfg_dir,
  output logic              cfg_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ie_q, irq_q, irq_d, done_q, dir_q, mode_q;

  logic wr_addr, wr_cnt, wr_ctrl, start_req, zero_go;
  assign wr_addr   = reg_wr && (reg_addr == 2'(OFS_ADDR));
  assign wr_cnt    = reg_wr && (reg_addr == 2'(OFS_COUNT));
  assign wr_ctrl   = reg_wr && (reg_addr == 2'(OFS_CTRL));
  assign start_req = wr_ctrl && reg_wdata[B_GO] && !busy;
  assign go        = start_req && (cnt_q != '0);
  assign zero_go   = start_req && (cnt_q == '0);
  assign go_dir    = reg_wdata[B_DIR];

  always_comb begin
    irq_d = irq_q;
    if (wr_ctrl && reg_wdata[B_IRQ]) irq_d = 1'b0;
    if (start_req)                   irq_d = 1'b0;
    if (finish && ie_q)              irq_d = 1'b1;
    if (zero_go && reg_wdata[B_IE])  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (wr_addr && !busy)  addr_q <= reg_wdata[ADDR_W-1:0];
      else if (step)         addr_q <= addr_q + ADDR_W'(WORD_BYTES);
      if (wr_cnt && !busy)   cnt_q <= reg_wdata[CNT_W-1:0];
      else if (step)         cnt_q <= cnt_q - CNT_W'(1);
      if (wr_ctrl) begin
        ie_q <= reg_wdata[B_IE];
        if (!busy) begin
          dir_q  <= reg_wdata[B_DIR];
          mode_q <= reg_wdata[B_MODE];
        end
      end
      if (finish || zero_go) done_q <= 1'b1;
      else if (go)           done_q <= 1'b0;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'(OFS_ADDR):  reg_rdata = 32'(addr_q);
      2'(OFS_COUNT): reg_rdata = 32'(cnt_q);
      2'(OFS_CTRL):  reg_rdata = {irq_q, ie_q, 26'b0, 1'b0, mode_q, dir_q, done_q};
      default:       reg_rdata = 32'b0;
    endcase
  end

  assign cfg_dir  = dir_q;
  assign cfg_mode = mode_q;
  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign irq      = irq_q;

  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == $past(addr_q) + ADDR_W'(WORD_BYTES)) && (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R2
  busy_addr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr && busy && !step |=> addr_q == $past(addr_q));
  // R4
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish && ie_q |=> irq && done_q);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && reg_wdata[B_IRQ] && !finish && !(zero_go && reg_wdata[B_IE]) |=> !irq);
  // R9
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_go |=> done_q && !busy);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_dir,
  input  logic              cfg_dir,
  input  logic              cfg_mode,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic              busy,
  output logic              step,
  output logic              finish,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [DATA_W-1:0] per_out_data
);
  phase_t            ph_q, ph_d;
  logic              own_q, own_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              last;

  assign last = (cur_cnt == CNT_W'(1));

  always_comb begin
    ph_d   = ph_q;
    own_d  = own_q;
    buf_d  = buf_q;
    step   = 1'b0;
    finish = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (go) ph_d = go_dir ? PH_FETCH : PH_REQ;
      PH_FETCH: if (per_in_valid) begin
        buf_d = per_in_data;
        ph_d  = own_q ? PH_MEM : PH_REQ;
      end
      PH_REQ: if (bus_grant) begin
        own_d = 1'b1;
        ph_d  = PH_MEM;
      end
      PH_MEM: if (mem_ready) begin
        step = 1'b1;
        if (!cfg_mode || last) own_d = 1'b0;
        if (cfg_dir) begin
          finish = last;
          ph_d   = last ? PH_IDLE : PH_FETCH;
        end else begin
          buf_d = mem_rdata;
          ph_d  = PH_PUSH;
        end
      end
      PH_PUSH: if (per_out_ready) begin
        if (cur_cnt == '0) begin
          finish = 1'b1;
          ph_d   = PH_IDLE;
        end else begin
          ph_d = own_q ? PH_MEM : PH_REQ;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      own_q <= 1'b0;
      buf_q <= '0;
    end else begin
      ph_q  <= ph_d;
      own_q <= own_d;
      buf_q <= buf_d;
    end
  end

  assign busy          = (ph_q != PH_IDLE);
  assign bus_req       = own_q || (ph_q == PH_REQ);
  assign mem_valid     = (ph_q == PH_MEM);
  assign mem_write     = cfg_dir;
  assign mem_wdata     = buf_q;
  assign per_in_ready  = (ph_q == PH_FETCH);
  assign per_out_valid = (ph_q == PH_PUSH);
  assign per_out_data  = buf_q;

  // R5
  mem_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req && own_q);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_REQ) && !bus_grant |=> bus_req);
  // R6
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode && mem_valid && mem_ready |=> !bus_req);
  // R7
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode && own_q && !(mem_valid && mem_ready && last) |=> bus_req);
  // R11
  mem_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_wdata));
  // R11
  out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_out_valid && !per_out_ready |=> per_out_valid && $stable(per_out_data));
  // R10
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, per_in_ready, per_out_valid}));
endmodule

// File: rtl/dma_block_ctrl.sv
module dma_block_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [DATA_W-1:0] per_out_data
);
  logic             busy, step, finish, go, go_dir, cfg_dir, cfg_mode;
  logic [CNT_W-1:0] cur_cnt;

  dma_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .step(step), .finish(finish),
    .go(go), .go_dir(go_dir), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode),
    .cur_addr(mem_addr), .cur_cnt(cur_cnt), .irq(irq)
  );

  dma_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_dir(go_dir), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode), .cur_cnt(cur_cnt),
    .busy(busy), .step(step), .finish(finish),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_in_valid(per_in_valid), .per_in_ready(per_in_ready), .per_in_data(per_in_data),
    .per_out_valid(per_out_valid), .per_out_ready(per_out_ready), .per_out_data(per_out_data)
  );
endmodule

// File: tb/tb_dma_block_ctrl.sv
module tb_dma_block_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, bus_req, mem_valid, mem_write, per_in_ready, per_out_valid;
  logic        bus_grant = 1'b0, mem_ready = 1'b0, per_in_valid = 1'b0, per_out_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, per_out_data;
  logic [31:0] mem_rdata = '0, per_in_data = '0;

  dma_block_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_in_valid(per_in_valid),
    .per_in_ready(per_in_ready), .per_in_data(per_in_data), .per_out_valid(per_out_valid),
    .per_out_ready(per_out_ready), .per_out_data(per_out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, rises = 0;
  bit armed = 0, prev_req = 0;
  int gdly = 0, gcnt = 0, mstall = 0, istall = 0, ostall = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] src[$];
  logic [31:0] rcv[$];

  // behavioural reference state
  int          m_ph = 0, n_ph;  // 0 idle 1 take-in 2 ask-bus 3 memory 4 hand-out
  bit          m_own, n_own, m_ie, n_ie, m_irq, n_irq, m_done, n_done, m_dir, n_dir, m_mode, n_mode;
  bit          m_busy, m_fin, m_stp;
  logic [31:0] m_addr, n_addr, m_buf, n_buf;
  logic [15:0] m_cnt, n_cnt;

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E37) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] memrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_addr;
      2'd1: return {16'b0, m_cnt};
      2'd2: return {m_irq, m_ie, 26'b0, 1'b0, m_mode, m_dir, m_done};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_own = 0; m_addr = 0; m_cnt = 0; m_ie = 0; m_irq = 0;
      m_done = 0; m_dir = 0; m_mode = 0; m_buf = 0; armed = 1;
    end else begin
      n_ph = m_ph; n_own = m_own; n_buf = m_buf; n_addr = m_addr; n_cnt = m_cnt;
      n_ie = m_ie; n_irq = m_irq; n_done = m_done; n_dir = m_dir; n_mode = m_mode;
      m_busy = (m_ph != 0); m_fin = 0; m_stp = 0;
      case (m_ph)
        1: if (per_in_valid) begin
             n_buf = per_in_data; void'(src.pop_front()); n_ph = m_own ? 3 : 2;
           end
        2: if (bus_grant) begin n_own = 1; n_ph = 3; end
        3: if (mem_ready) begin
             m_stp = 1;
             if (!m_mode || m_cnt == 1) n_own = 0;
             if (m_dir) begin
               mem[m_addr] = m_buf;
               if (m_cnt == 1) begin m_fin = 1; n_ph = 0; end else n_ph = 1;
             end else begin
               n_buf = mem_rdata; n_ph = 4;
             end
           end
        4: if (per_out_ready) begin
             rcv.push_back(m_buf);
             if (m_cnt == 0) begin m_fin = 1; n_ph = 0; end else n_ph = m_own ? 3 : 2;
           end
        default: ;
      endcase
      if (m_stp) begin n_addr = m_addr + 4; n_cnt = m_cnt - 1; end
      if (reg_wr) begin
        case (reg_addr)
          2'd0: if (!m_busy) n_addr = reg_wdata;
          2'd1: if (!m_busy) n_cnt = reg_wdata[15:0];
          2'd2: begin
            n_ie = reg_wdata[30];
            if (reg_wdata[31]) n_irq = 0;
            if (!m_busy) begin
              n_dir = reg_wdata[1]; n_mode = reg_wdata[2];
              if (reg_wdata[3]) begin
                n_done = 0; n_irq = 0;
                if (m_cnt == 0) begin n_done = 1; if (reg_wdata[30]) n_irq = 1; end
                else n_ph = reg_wdata[1] ? 1 : 2;
              end
            end
          end
          default: ;
        endcase
      end
      if (m_fin) begin n_done = 1; if (m_ie) n_irq = 1; end
      m_ph = n_ph; m_own = n_own; m_buf = n_buf; m_addr = n_addr; m_cnt = n_cnt;
      m_ie = n_ie; m_irq = n_irq; m_done = n_done; m_dir = n_dir; m_mode = n_mode;
    end
  end

  // environment: arbiter, memory and peripheral, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    if (m_own || m_ph == 2) begin
      if (gcnt >= gdly) bus_grant = 1'b1; else gcnt++;
    end else begin
      bus_grant = 1'b0; gcnt = 0;
    end
    mem_ready     = (mstall == 0) || (cyc % mstall != 0);
    per_in_valid  = (src.size() > 0) && ((istall == 0) || (cyc % istall != 0));
    per_in_data   = (src.size() > 0) ? src[0] : 32'h0;
    per_out_ready = (ostall == 0) || (cyc % ostall != 0);
    mem_rdata     = memrd(m_addr);
  end

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    if (armed) begin
      chk("R5 bus_req", 32'(bus_req), 32'(m_own || m_ph == 2));
      chk("R5 mem_valid", 32'(mem_valid), 32'(m_ph == 3));
      chk("R10 per_in_ready", 32'(per_in_ready), 32'(m_ph == 1));
      chk("R11 per_out_valid", 32'(per_out_valid), 32'(m_ph == 4));
      chk("R4 irq", 32'(irq), 32'(m_irq));
      chk("R2 reg_rdata", reg_rdata, exp_rd(reg_addr));
      if (m_ph == 3) begin
        chk("R3 mem_addr", mem_addr, m_addr);
        chk("R10 mem_write", 32'(mem_write), 32'(m_dir));
        if (m_dir) chk("R11 mem_wdata", mem_wdata, m_buf);
      end
      if (m_ph == 4) chk("R11 per_out_data", per_out_data, m_buf);
      if (!prev_req && bus_req) rises++;
      prev_req = bus_req;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_done();
    @(posedge clk); #1;
    reg_addr = 2'd2;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (reg_rdata[0]) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 actual=no-completion expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state through the register port
    rd_chk("R1 address after reset", 2'd0, 32'h0);
    rd_chk("R1 count after reset", 2'd1, 32'h0);
    rd_chk("R1 control after reset", 2'd2, 32'h0);

    // memory to peripheral, cycle stealing, stalls everywhere
    gdly = 2; mstall = 3; ostall = 2; rises = 0;
    reg_write(2'd0, 32'h100);
    reg_write(2'd1, 32'd4);
    reg_write(2'd2, 32'h4000_0008);
    repeat (6) @(posedge clk);
    reg_write(2'd0, 32'hDEAD_0000);   // R2: ignored while busy
    reg_write(2'd1, 32'd99);
    wait_done();
    chk("R6 request episodes, steal", 32'(rises), 32'd4);
    chk("R10 words delivered", 32'(rcv.size()), 32'd4);
    for (int i = 0; i < 4; i++)
      chk("R10 delivered word", (i < rcv.size()) ? rcv[i] : 32'hX, pat(32'h100 + 32'(4*i)));
    chk("R4 irq after completion", 32'(irq), 32'd1);
    rd_chk("R3 final address", 2'd0, 32'h110);
    rd_chk("R3 final count", 2'd1, 32'd0);
    reg_write(2'd2, 32'h8000_0000);
    @(negedge clk);
    chk("R8 irq cleared by write-one", 32'(irq), 32'd0);

    // peripheral to memory, block mode
    gdly = 3; mstall = 2; istall = 3; rises = 0;
    for (int i = 0; i < 5; i++) src.push_back(32'hC0DE_0000 + 32'(i));
    reg_write(2'd0, 32'h200);
    reg_write(2'd1, 32'd5);
    reg_write(2'd2, 32'h0000_000E);
    wait_done();
    chk("R7 request episodes, block", 32'(rises), 32'd1);
    for (int i = 0; i < 5; i++)
      chk("R10 stored word", memrd(32'h200 + 32'(4*i)), 32'hC0DE_0000 + 32'(i));
    chk("R4 irq stays low when disabled", 32'(irq), 32'd0);

    // zero count start with interrupt enabled
    rises = 0;
    reg_write(2'd1, 32'd0);
    reg_write(2'd2, 32'h4000_0008);
    rd_chk("R9 zero count start completes", 2'd2, 32'hC000_0001);
    repeat (4) @(posedge clk);
    chk("R9 zero count never asks for bus", 32'(rises), 32'd0);

    // memory to peripheral, block mode; start clears the pending irq
    gdly = 1; mstall = 0; ostall = 3; rises = 0; rcv.delete();
    reg_write(2'd0, 32'h300);
    reg_write(2'd1, 32'd3);
    reg_write(2'd2, 32'h4000_000C);
    @(negedge clk);
    chk("R9 start clears irq", 32'(irq), 32'd0);
    wait_done();
    chk("R7 request episodes, block read", 32'(rises), 32'd1);
    for (int i = 0; i < 3; i++)
      chk("R10 block delivered word", (i < rcv.size()) ? rcv[i] : 32'hX, pat(32'h300 + 32'(4*i)));
    chk("R4 irq on block completion", 32'(irq), 32'd1);

    // peripheral to memory, cycle stealing, no interrupt
    gdly = 0; mstall = 4; istall = 2; rises = 0;
    reg_write(2'd2, 32'h8000_0000);
    for (int i = 0; i < 3; i++) src.push_back(32'hBEEF_0100 + 32'(i));
    reg_write(2'd0, 32'h400);
    reg_write(2'd1, 32'd3);
    reg_write(2'd2, 32'h0000_000A);
    wait_done();
    chk("R6 request episodes, steal write", 32'(rises), 32'd3);
    for (int i = 0; i < 3; i++)
      chk("R10 steal stored word", memrd(32'h400 + 32'(4*i)), 32'hBEEF_0100 + 32'(i));
    rd_chk("R3 address after steal write", 2'd0, 32'h40C);
    rd_chk("R9 control after finish", 2'd2, 32'h0000_0003);

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule